// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block produces the internal reset of a small microcontroller-class chip. It combines a power-on pulse, an optional active-low reset pin and a watchdog time-out. After power-on it adds two start-up delays in sequence. The first is a power-up delay that counts pulses of an independent on-chip RC tick. The second is an oscillator settling delay that counts cycles of the main clock. The settling delay applies only when the clock comes from a crystal or resonator. The same settling delay also holds the core when it wakes from sleep. In that case it runs alone, and no reset is raised.

Three cause flags tell software why the core is starting. The power-on flag is cleared by power-on and set only by software. The time-out flag is cleared by a watchdog time-out. The power-down flag is cleared by entering sleep. Power-on sets both the time-out and the power-down flags. A busy output is high while either delay counter is running.

The oscillator mode uses the following code values. `osc_mode_i` = 0, 1 and 2 are the crystal and resonator modes: low-power, standard and high-speed. Codes 3 to 7 are RC modes and need no settling delay.

Top module: `boot_rst_seq`

## Requirements
- R1: While `por_i` is high, `rst_o` = 1, `to_flag_o` = 1, `pd_flag_o` = 1 and `por_flag_o` = 0.
- R2: With `pwrt_en_i` = 1 and a crystal mode (codes 0 to 2), `rst_o` stays high for 1 + PWRT_TICKS + OST_CYCLES clock cycles after `por_i` falls, given a tick on every cycle. The settling count starts only when the power-up count has finished.
- R3: In an RC mode (codes 3 to 7) no settling delay is applied. With `pwrt_en_i` = 1, `rst_o` stays high for 1 + PWRT_TICKS cycles. With `pwrt_en_i` = 0, it stays high for 1 cycle.
- R4: With `pwrt_en_i` = 0 the tick is not counted. In a crystal mode `rst_o` stays high for 1 + OST_CYCLES cycles.
- R5: A `wake_i` pulse while asleep in a crystal mode raises `busy_o` for exactly OST_CYCLES cycles and does not raise `rst_o`. In an RC mode the core resumes at once, and `busy_o` stays low.
- R6: When `ext_rst_en_i` = 1, a low `ext_rst_n_i` drives `rst_o` high in the same cycle, and it also ends sleep. When `ext_rst_en_i` = 0, the pin has no effect on `rst_o`.
- R7: A `wdt_tmo_i` pulse while running raises `rst_o` for exactly one cycle and clears `to_flag_o`. A `wdt_tmo_i` pulse while asleep clears `to_flag_o` and wakes the core without any reset.
- R8: A `sleep_i` pulse while running and out of reset clears `pd_flag_o` and puts the core to sleep.
- R9: `por_flag_set_i` sets `por_flag_o`. Pin and watchdog resets leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| por_i | input | 1 | Power-on pulse, asynchronous, active high |
| rc_tick_i | input | 1 | One-cycle enable from the on-chip RC source |
| ext_rst_n_i | input | 1 | Reset pin, active low, already synchronised |
| ext_rst_en_i | input | 1 | Configuration: reset pin enabled |
| pwrt_en_i | input | 1 | Configuration: power-up delay enabled |
| osc_mode_i | input | 3 | Oscillator mode code; 0 to 2 are crystal modes |
| wdt_tmo_i | input | 1 | Watchdog time-out pulse |
| sleep_i | input | 1 | Sleep instruction executed |
| wake_i | input | 1 | Wake-up event while asleep |
| por_flag_set_i | input | 1 | Software sets the power-on flag |
| rst_o | output | 1 | Internal chip reset |
| busy_o | output | 1 | A start-up delay counter is running |
| por_flag_o | output | 1 | Power-on flag; 0 after power-on |
| to_flag_o | output | 1 | Time-out flag; 0 after a watchdog time-out |
| pd_flag_o | output | 1 | Power-down flag; 0 after sleep |

## Verification
A counter that is off by one, or a phase order that is wrong, shows up directly on the ports. The cycle on which `rst_o` or `busy_o` falls moves by one or more cycles, or by a whole delay when a phase is skipped or run twice. A sequencing state that is wrong, such as sleep not being left or a watchdog pulse taken as a reset during sleep, appears on `rst_o` or the cause flags within one cycle of the event. For that reason every output is compared with a reference model on every cycle, and the release lengths are also measured as whole-cycle counts.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   localparam int OSC_MODE_W = 3;

   localparam logic [OSC_MODE_W-1:0] OSC_LOWPWR_XTAL = 3'd0;
   localparam logic [OSC_MODE_W-1:0] OSC_STD_XTAL    = 3'd1;
   localparam logic [OSC_MODE_W-1:0] OSC_FAST_XTAL   = 3'd2;

   typedef enum logic [2:0] {
      SQ_START,
      SQ_PWRUP,
      SQ_OSCST,
      SQ_RUN,
      SQ_SLEEP,
      SQ_WAKE
   } sq_state_t;

   function automatic logic needs_settle(input logic [OSC_MODE_W-1:0] mode);
      return (mode == OSC_LOWPWR_XTAL) || (mode == OSC_STD_XTAL) || (mode == OSC_FAST_XTAL);
   endfunction
endpackage

// File: rtl/rsq_span_cnt.sv
module rsq_span_cnt #(
   parameter int TERMINAL = 1024,
   localparam int CW = $clog2(TERMINAL)
) (
   input  logic clk_i,
   input  logic arst_i,
   input  logic run_i,
   input  logic step_i,
   output logic done_o
);
   logic [CW-1:0] cnt_q;
   logic          at_end;

   generate
      if (TERMINAL < 2) begin : g_bad
         $error("rsq_span_cnt: TERMINAL must be at least 2");
      end
      if ((1 << CW) == TERMINAL) begin : g_pow2
         assign at_end = &cnt_q;
      end else begin : g_cmp
         assign at_end = (cnt_q == CW'(TERMINAL - 1));
      end
   endgenerate

   assign done_o = run_i & step_i & at_end;

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i)        cnt_q <= '0;
      else if (!run_i)   cnt_q <= '0;
      else if (step_i)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/rsq_cause_flags.sv
module rsq_cause_flags (
   input  logic clk_i,
   input  logic arst_i,
   input  logic wdt_hit_i,
   input  logic sleep_hit_i,
   input  logic sw_set_i,
   output logic por_flag_o,
   output logic to_flag_o,
   output logic pd_flag_o
);
   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) begin
         por_flag_o <= 1'b0;
         to_flag_o  <= 1'b1;
         pd_flag_o  <= 1'b1;
      end else begin
         if (sw_set_i)    por_flag_o <= 1'b1;
         if (wdt_hit_i)   to_flag_o  <= 1'b0;
         if (sleep_hit_i) pd_flag_o  <= 1'b0;
      end
   end

   AST_TO_CAUSE: assert property (@(posedge clk_i) disable iff (arst_i)
      $fell(to_flag_o) |-> $past(wdt_hit_i)); // R7
   AST_PD_CAUSE: assert property (@(posedge clk_i) disable iff (arst_i)
      $fell(pd_flag_o) |-> $past(sleep_hit_i)); // R8
   AST_PORF_CAUSE: assert property (@(posedge clk_i) disable iff (arst_i)
      $rose(por_flag_o) |-> $past(sw_set_i)); // R9
   AST_PORF_STICKY: assert property (@(posedge clk_i) disable iff (arst_i)
      $past(por_flag_o) |-> por_flag_o); // R9
endmodule

// File: rtl/boot_rst_seq.sv
module boot_rst_seq
   import rsq_pkg::*;
#(
   parameter int PWRT_TICKS = 1024,
   parameter int OST_CYCLES = 1024
) (
   input  logic                  clk_i,
   input  logic                  por_i,
   input  logic                  rc_tick_i,
   input  logic                  ext_rst_n_i,
   input  logic                  ext_rst_en_i,
   input  logic                  pwrt_en_i,
   input  logic [OSC_MODE_W-1:0] osc_mode_i,
   input  logic                  wdt_tmo_i,
   input  logic                  sleep_i,
   input  logic                  wake_i,
   input  logic                  por_flag_set_i,
   output logic                  rst_o,
   output logic                  busy_o,
   output logic                  por_flag_o,
   output logic                  to_flag_o,
   output logic                  pd_flag_o
);
   sq_state_t state_q, state_d;
   logic      wdt_q, wdt_d;
   logic      pw_done, os_done;
   logic      ext_act, xtal, wdt_hit, sleep_hit, run_ok;

   assign ext_act = ext_rst_en_i & ~ext_rst_n_i;
   assign xtal    = needs_settle(osc_mode_i);
   assign run_ok  = (state_q == SQ_RUN) & ~ext_act & ~wdt_q;

   rsq_span_cnt #(.TERMINAL(PWRT_TICKS)) i_pwrt_cnt (
      .clk_i  (clk_i),
      .arst_i (por_i),
      .run_i  (state_q == SQ_PWRUP),
      .step_i (rc_tick_i),
      .done_o (pw_done)
   );

   rsq_span_cnt #(.TERMINAL(OST_CYCLES)) i_ost_cnt (
      .clk_i  (clk_i),
      .arst_i (por_i),
      .run_i  ((state_q == SQ_OSCST) || (state_q == SQ_WAKE)),
      .step_i (1'b1),
      .done_o (os_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_START: state_d = pwrt_en_i ? SQ_PWRUP : (xtal ? SQ_OSCST : SQ_RUN);
         SQ_PWRUP: if (pw_done) state_d = xtal ? SQ_OSCST : SQ_RUN;
         SQ_OSCST: if (os_done) state_d = SQ_RUN;
         SQ_RUN:   if (run_ok && !wdt_tmo_i && sleep_i) state_d = SQ_SLEEP;
         SQ_SLEEP: begin
            if (ext_act)                   state_d = SQ_RUN;
            else if (wdt_tmo_i || wake_i)  state_d = xtal ? SQ_WAKE : SQ_RUN;
         end
         SQ_WAKE:  if (ext_act || os_done) state_d = SQ_RUN;
         default:  state_d = SQ_START;
      endcase
   end

   assign wdt_d     = run_ok & wdt_tmo_i;
   assign sleep_hit = run_ok & ~wdt_tmo_i & sleep_i;
   assign wdt_hit   = wdt_d | ((state_q == SQ_SLEEP) & ~ext_act & wdt_tmo_i);

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         state_q <= SQ_START;
         wdt_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         wdt_q   <= wdt_d;
      end
   end

   rsq_cause_flags i_flags (
      .clk_i       (clk_i),
      .arst_i      (por_i),
      .wdt_hit_i   (wdt_hit),
      .sleep_hit_i (sleep_hit),
      .sw_set_i    (por_flag_set_i),
      .por_flag_o  (por_flag_o),
      .to_flag_o   (to_flag_o),
      .pd_flag_o   (pd_flag_o)
   );

   assign rst_o  = (state_q == SQ_START) || (state_q == SQ_PWRUP) || (state_q == SQ_OSCST)
                   || ext_act || wdt_q;
   assign busy_o = (state_q == SQ_PWRUP) || (state_q == SQ_OSCST) || (state_q == SQ_WAKE);

   AST_OST_AFTER_PWRT: assert property (@(posedge clk_i) disable iff (por_i)
      (state_q == SQ_OSCST && $past(state_q) == SQ_PWRUP) |-> $past(pw_done)); // R2
   AST_RUN_AFTER_OST: assert property (@(posedge clk_i) disable iff (por_i)
      (state_q == SQ_RUN && $past(state_q) == SQ_OSCST) |-> $past(os_done)); // R2
   AST_RC_NO_SETTLE: assert property (@(posedge clk_i) disable iff (por_i)
      (state_q == SQ_OSCST && $past(state_q) != SQ_OSCST) |-> $past(xtal)); // R3
   AST_WAKE_NO_RESET: assert property (@(posedge clk_i) disable iff (por_i)
      (state_q == SQ_WAKE && !ext_act) |-> !rst_o); // R5
   AST_PIN_IGNORED: assert property (@(posedge clk_i) disable iff (por_i)
      (!ext_rst_en_i && state_q == SQ_RUN && !wdt_q) |-> !rst_o); // R6
   AST_WDT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (por_i)
      wdt_q |=> !wdt_q); // R7
endmodule

// File: tb/test_boot_rst_seq.sv
`timescale 1ns/100ps
module test_boot_rst_seq;
   localparam int PW = 1024;
   localparam int OS = 1024;

   logic clk = 1'b0;
   logic por = 1'b1, tick = 1'b1, pin_n = 1'b1, pin_en = 1'b1, pwrt_en = 1'b1;
   logic [2:0] mode = 3'd1;
   logic wdt = 1'b0, slp = 1'b0, wake = 1'b0, sw_set = 1'b0;
   logic rst, busy, porf, tof, pdf;
   int   total = 0, bad = 0;
   int   tick_div = 1;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   boot_rst_seq #(.PWRT_TICKS(PW), .OST_CYCLES(OS)) i_boot_rst_seq (
      .clk_i(clk), .por_i(por), .rc_tick_i(tick), .ext_rst_n_i(pin_n),
      .ext_rst_en_i(pin_en), .pwrt_en_i(pwrt_en), .osc_mode_i(mode),
      .wdt_tmo_i(wdt), .sleep_i(slp), .wake_i(wake), .por_flag_set_i(sw_set),
      .rst_o(rst), .busy_o(busy), .por_flag_o(porf), .to_flag_o(tof), .pd_flag_o(pdf));

   // reference model: 0 start, 1 power-up delay, 2 settle, 3 run, 4 asleep, 5 wake settle
   int m_st, m_pc, m_oc;
   bit m_wq, m_to, m_pd, m_pf;

   function automatic bit xt(input logic [2:0] m);
      return m <= 3'd2;
   endfunction
   function automatic bit m_ext();
      return pin_en && !pin_n;
   endfunction

   always @(posedge clk or posedge por) begin
      if (por) begin
         m_st = 0; m_pc = 0; m_oc = 0; m_wq = 0; m_to = 1; m_pd = 1; m_pf = 0;
      end else begin
         bit nwq;
         nwq = 0;
         if (sw_set) m_pf = 1;
         case (m_st)
            0: begin m_pc = 0; m_oc = 0; m_st = pwrt_en ? 1 : (xt(mode) ? 2 : 3); end
            1: if (tick) begin
                  m_pc++;
                  if (m_pc == PW) begin m_st = xt(mode) ? 2 : 3; m_oc = 0; end
               end
            2: begin m_oc++; if (m_oc == OS) m_st = 3; end
            3: if (!m_ext() && !m_wq) begin
                  if (wdt) begin nwq = 1; m_to = 0; end
                  else if (slp) begin m_st = 4; m_pd = 0; end
               end
            4: if (m_ext()) m_st = 3;
               else if (wdt || wake) begin
                  if (wdt) m_to = 0;
                  m_oc = 0; m_st = xt(mode) ? 5 : 3;
               end
            5: if (m_ext()) m_st = 3;
               else begin m_oc++; if (m_oc == OS) m_st = 3; end
            default: m_st = 0;
         endcase
         m_wq = nwq;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle compare against the model
   always @(negedge clk) if (!done) begin
      bit e_rst, e_busy;
      e_rst  = (m_st <= 2) || m_ext() || m_wq;
      e_busy = (m_st == 1) || (m_st == 2) || (m_st == 5);
      if (rst !== e_rst)   chk(0, "R2 model rst_o", rst, e_rst);
      if (busy !== e_busy) chk(0, "R5 model busy_o", busy, e_busy);
      if (tof !== m_to)    chk(0, "R7 model to_flag_o", tof, m_to);
      if (pdf !== m_pd)    chk(0, "R8 model pd_flag_o", pdf, m_pd);
      if (porf !== m_pf)   chk(0, "R9 model por_flag_o", porf, m_pf);
   end

   // RC tick source
   initial begin
      int ph = 0;
      forever begin
         @(posedge clk); #1;
         ph++;
         tick = (ph % tick_div) == 0;
      end
   end

   initial begin
      #(200000 * 5);
      chk(0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic do_por(input bit pe, input logic [2:0] md, output int n);
      @(posedge clk); #1;
      por = 1'b1; pwrt_en = pe; mode = md;
      cyc(2);
      por = 1'b0;
      n = 0;
      forever begin
         @(negedge clk);
         if (rst) n++; else break;
      end
   endtask

   task automatic pulse(ref logic s);
      @(posedge clk); #1; s = 1'b1;
      @(posedge clk); #1; s = 1'b0;
   endtask

   initial begin
      int n, nb;
      bit saw_rst;
      cyc(2);
      @(negedge clk);
      chk(rst === 1'b1, "R1 rst_o during por", rst, 1);
      chk(tof === 1'b1 && pdf === 1'b1, "R1 to/pd during por", {tof, pdf}, 3);
      chk(porf === 1'b0, "R1 por_flag during por", porf, 0);

      do_por(1'b1, 3'd1, n);
      chk(n == 1 + PW + OS, "R2 release, delay and xtal", n, 1 + PW + OS);
      do_por(1'b1, 3'd4, n);
      chk(n == 1 + PW, "R3 release, delay and RC", n, 1 + PW);
      do_por(1'b0, 3'd2, n);
      chk(n == 1 + OS, "R4 release, no delay and xtal", n, 1 + OS);
      do_por(1'b0, 3'd5, n);
      chk(n == 1, "R3 release, no delay and RC", n, 1);

      pulse(sw_set);
      @(negedge clk);
      chk(porf === 1'b1, "R9 software sets por flag", porf, 1);
      pulse(slp);
      @(negedge clk);
      chk(pdf === 1'b0, "R8 sleep clears pd", pdf, 0);
      mode = 3'd1;
      pulse(wake);
      nb = 0; saw_rst = 0;
      forever begin
         @(negedge clk);
         if (rst) saw_rst = 1;
         if (busy) nb++; else break;
      end
      chk(nb == OS, "R5 wake settle length", nb, OS);
      chk(!saw_rst, "R5 no reset on wake", saw_rst, 0);

      mode = 3'd6;
      pulse(slp);
      pulse(wake);
      @(negedge clk);
      chk(busy === 1'b0 && rst === 1'b0, "R5 RC wake resumes", {busy, rst}, 0);

      @(posedge clk); #1; pin_en = 1'b1; pin_n = 1'b0;
      @(negedge clk);
      chk(rst === 1'b1, "R6 pin asserts reset", rst, 1);
      cyc(3); pin_n = 1'b1;
      @(negedge clk);
      chk(rst === 1'b0 && porf === 1'b1, "R9 pin reset keeps por flag", {rst, porf}, 1);
      @(posedge clk); #1; pin_en = 1'b0; pin_n = 1'b0;
      cyc(2);
      @(negedge clk);
      chk(rst === 1'b0, "R6 disabled pin ignored", rst, 0);
      pin_n = 1'b1; pin_en = 1'b1;

      pulse(wdt);
      @(negedge clk);
      chk(rst === 1'b1 && tof === 1'b0, "R7 watchdog reset and flag", {rst, tof}, 2);
      @(negedge clk);
      chk(rst === 1'b0 && porf === 1'b1, "R7 watchdog reset one cycle", {rst, porf}, 1);

      do_por(1'b0, 3'd3, n);
      mode = 3'd0;
      pulse(slp);
      pulse(wdt);
      @(negedge clk);
      chk(tof === 1'b0 && rst === 1'b0 && busy === 1'b1, "R7 watchdog wakes from sleep",
          {tof, rst, busy}, 1);
      cyc(OS + 2);
      pulse(slp);
      @(posedge clk); #1; pin_n = 1'b0;
      @(posedge clk); #1; pin_n = 1'b1;
      @(negedge clk);
      chk(rst === 1'b0 && busy === 1'b0, "R6 pin ends sleep", {rst, busy}, 0);
      pulse(slp);
      @(negedge clk);
      chk(pdf === 1'b0, "R8 sleep after pin", pdf, 0);

      tick_div = 3;
      do_por(1'b1, 3'd2, n);
      chk(n > 3 * PW, "R2 slow tick lengthens delay", n, 3 * PW);
      cyc(20);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule